// File: doc/BRIEF.md
# Edge-Triggered Interrupt Status Controller

This block gathers single-cycle event pulses from the timer, the analog output and analog input converters, four counter channels, a status-only memory event, and edge events detected on eight asynchronous digital pins. The pulses are latched into one 16-bit sticky status register. A 16-bit enable register selects which latched bits raise the single interrupt output.

Each digital pin is synchronized by two flops before its edges are detected. Pins 0 to 3 each have their own edge-polarity bit. Pins 4 to 7 share one polarity bit. The same control register also holds the output-direction bit of each 4-bit pin group. The host acknowledges an event by writing a one to the status bit it saw. Writes go through a simple write strobe with a 2-bit register select, and all three registers are always visible on output ports.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset the status, enable and control registers are all zero, the group direction outputs are zero and `irq` is low.
- R2: A one-cycle pulse on `tmr_evt`, `dac_evt`, `adc_evt` or `mem_evt` sets status bit 0, 1, 2 or 7 respectively on the next clock edge. The bit then stays set until it is cleared.
- R3: A pulse on `cnt_evt[n]` sets status bit 6-n, so counter 0 maps to bit 6 and counter 3 maps to bit 3.
- R4: An active edge on `pin_in[i]` sets status bit 8+i. The bit becomes visible after the third rising clock edge that follows the pin change: two synchronizer stages, then the detect-and-latch stage.
- R5: For pins 0 to 3, control bit 12+i selects the active edge of pin i: 0 selects rising and 1 selects falling. An edge of the other sense has no effect.
- R6: Control bit 8 selects the active edge for all of pins 4 to 7, with the same encoding as R5.
- R7: A write with `wr_sel`=2 loads the control register. Only bits 15:12, 11, 10 and 8 are stored and all other bits read 0. `grp_dir[0]` follows bit 10 (pins 0-3 driven as outputs) and `grp_dir[1]` follows bit 11 (pins 4-7 driven as outputs).
- R8: A write with `wr_sel`=0 clears every status bit whose data bit is 1. Status bits whose data bit is 0 are unchanged.
- R9: When an event and a clear of the same status bit fall in the same cycle, the bit ends up set.
- R10: A write with `wr_sel`=1 loads the enable register. Bit 7 always stays 0.
- R11: `irq` is high exactly when some status bit is set and its enable bit is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_evt | input | 1 | Timer event pulse |
| dac_evt | input | 1 | Analog output done pulse |
| adc_evt | input | 1 | Analog input done pulse |
| cnt_evt | input | 4 | Counter channel event pulses |
| mem_evt | input | 1 | Memory event pulse (status only) |
| pin_in | input | 8 | Asynchronous digital pin levels |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 status (write-one-to-clear), 1 enable, 2 control |
| wr_data | input | 16 | Write data |
| status | output | 16 | Latched status register |
| irq_en | output | 16 | Enable register |
| dio_ctrl | output | 16 | Pin control register |
| grp_dir | output | 2 | Output direction of pin groups 0-3 and 4-7 |
| irq | output | 1 | Interrupt request |

## Verification
The two functions that can meet in one cycle are event latching and the host clear of the same status bit. The bench provokes this in a directed case, where a timer pulse and a write-one-to-clear of bit 0 are driven in the same cycle, and it expects the bit to remain set. A long random phase then drives events and status clears together on every clock. Each cycle is judged against a behavioural model that applies the clear first and the set afterwards, so any bit lost to a colliding clear is reported in that same cycle.

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tmr_evt,
  input  logic          dac_evt,
  input  logic          adc_evt,
  input  logic [3:0]    cnt_evt,
  input  logic          mem_evt,
  input  logic [7:0]    pin_in,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] status,
  output logic [DW-1:0] irq_en,
  output logic [DW-1:0] dio_ctrl,
  output logic [1:0]    grp_dir,
  output logic          irq
);
  localparam logic [1:0]    SEL_STAT = 2'd0;
  localparam logic [1:0]    SEL_EN   = 2'd1;
  localparam logic [1:0]    SEL_DIO  = 2'd2;
  localparam logic [DW-1:0] EN_MASK  = 16'hFF7F;
  localparam logic [DW-1:0] DIO_MASK = 16'hFD00;

  logic [7:0]    sync1, sync2, prev;
  logic [7:0]    pol, pin_hit;
  logic [DW-1:0] set_vec, clr_vec;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
      prev  <= sync2;
    end

  assign pol     = {{4{dio_ctrl[8]}}, dio_ctrl[15:12]};
  assign pin_hit = (sync2 & ~prev & ~pol) | (~sync2 & prev & pol);

  assign set_vec = {pin_hit, mem_evt, cnt_evt[0], cnt_evt[1], cnt_evt[2], cnt_evt[3],
                    adc_evt, dac_evt, tmr_evt};
  assign clr_vec = (wr_en && wr_sel == SEL_STAT) ? wr_data : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      status   <= '0;
      irq_en   <= '0;
      dio_ctrl <= '0;
    end else begin
      status <= (status & ~clr_vec) | set_vec;
      if (wr_en && wr_sel == SEL_EN)  irq_en   <= wr_data & EN_MASK;
      if (wr_en && wr_sel == SEL_DIO) dio_ctrl <= wr_data & DIO_MASK;
    end

  assign grp_dir = dio_ctrl[11:10];
  assign irq     = |(status & irq_en);

  AST_TMR_LATCH:    assert property (@(posedge clk) disable iff (!rst_n) tmr_evt |=> status[0]); // R2
  AST_CNT0_BIT6:    assert property (@(posedge clk) disable iff (!rst_n) cnt_evt[0] |=> status[6]); // R3
  AST_STICKY:       assert property (@(posedge clk) disable iff (!rst_n)
                      1'b1 |=> (($past(status) & ~$past(clr_vec) & ~status) == '0)); // R8
  AST_CLEAR_WORKS:  assert property (@(posedge clk) disable iff (!rst_n)
                      1'b1 |=> ((status & $past(clr_vec) & ~$past(set_vec)) == '0)); // R8
  AST_EVENT_WINS:   assert property (@(posedge clk) disable iff (!rst_n)
                      (tmr_evt && clr_vec[0]) |=> status[0]); // R9
  AST_MEM_NO_EN:    assert property (@(posedge clk) disable iff (!rst_n) !irq_en[7]); // R10
  AST_IRQ_SOURCE:   assert property (@(posedge clk) disable iff (!rst_n)
                      irq |-> (status != '0 && irq_en != '0)); // R11
  AST_DIR_HOLD:     assert property (@(posedge clk) disable iff (!rst_n)
                      !(wr_en && wr_sel == SEL_DIO) |=> $stable(grp_dir)); // R7
endmodule

// File: tb/tb_edge_irq_ctrl.sv
`timescale 1ns/1ps
module tb_edge_irq_ctrl;
  logic clk = 0, rst_n = 0;
  logic tmr_evt = 0, dac_evt = 0, adc_evt = 0, mem_evt = 0;
  logic [3:0] cnt_evt = 0;
  logic [7:0] pin_in = 0;
  logic wr_en = 0;
  logic [1:0] wr_sel = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] status, irq_en, dio_ctrl;
  logic [1:0] grp_dir;
  logic irq;

  int tests = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";

  edge_irq_ctrl dut (.clk, .rst_n, .tmr_evt, .dac_evt, .adc_evt, .cnt_evt, .mem_evt,
                     .pin_in, .wr_en, .wr_sel, .wr_data, .status, .irq_en, .dio_ctrl,
                     .grp_dir, .irq);

  always #2.5 clk = ~clk;

  logic [15:0] m_stat = 0, m_en = 0, m_ctrl = 0;
  logic [7:0] h0 = 0, h1 = 0, h2 = 0;

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    logic [15:0] ns;
    if (!rst_n) begin
      m_stat = 0; m_en = 0; m_ctrl = 0; h0 = 0; h1 = 0; h2 = 0;
    end else begin
      ns = m_stat;
      if (wr_en && wr_sel == 0) ns = ns & ~wr_data;
      if (tmr_evt) ns[0] = 1;
      if (dac_evt) ns[1] = 1;
      if (adc_evt) ns[2] = 1;
      if (mem_evt) ns[7] = 1;
      for (int n = 0; n < 4; n++) if (cnt_evt[n]) ns[3 + (3 - n)] = 1;
      for (int i = 0; i < 8; i++) begin
        bit falling;
        falling = (i < 4) ? m_ctrl[12 + i] : m_ctrl[8];
        if (falling ? (h2[i] && !h1[i]) : (!h2[i] && h1[i])) ns[8 + i] = 1;
      end
      if (wr_en && wr_sel == 1) m_en = wr_data & 16'hFF7F;
      if (wr_en && wr_sel == 2) m_ctrl = wr_data & 16'hFD00;
      m_stat = ns;
      h2 = h1; h1 = h0; h0 = pin_in;
    end
    #1;
    chk(cur_req, "status", status, m_stat);
    chk(cur_req, "irq_en", irq_en, m_en);
    chk(cur_req, "dio_ctrl", dio_ctrl, m_ctrl);
    chk(cur_req, "grp_dir", {14'd0, grp_dir}, {14'd0, m_ctrl[11:10]});
    chk(cur_req, "irq", {15'd0, irq}, {15'd0, |(m_stat & m_en)});
  end

  task automatic idle(int n); repeat (n) @(negedge clk); endtask

  task automatic wr(logic [1:0] s, logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse(logic t, logic da, logic ad, logic [3:0] c, logic m);
    @(negedge clk); tmr_evt = t; dac_evt = da; adc_evt = ad; cnt_evt = c; mem_evt = m;
    @(negedge clk); tmr_evt = 0; dac_evt = 0; adc_evt = 0; cnt_evt = 0; mem_evt = 0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    cur_req = "R1";
    chk("R1", "reset status", status, 16'h0000);
    chk("R1", "reset ctrl", dio_ctrl, 16'h0000);
    chk("R1", "reset irq", {15'd0, irq}, 16'h0000);
    rst_n = 1;
    idle(2);

    cur_req = "R3";
    pulse(0, 0, 0, 4'b0001, 0);
    chk("R3", "counter0 bit", status, 16'h0040);
    wr(0, 16'hFFFF);
    pulse(0, 0, 0, 4'b1000, 0);
    chk("R3", "counter3 bit", status, 16'h0008);

    cur_req = "R2";
    wr(0, 16'hFFFF);
    pulse(1, 1, 1, 4'b0000, 1);
    chk("R2", "periph bits", status, 16'h0087);
    idle(3);
    chk("R2", "sticky", status, 16'h0087);

    cur_req = "R8";
    wr(0, 16'h0005);
    chk("R8", "partial clear", status, 16'h0082);
    wr(0, 16'hFFFF);
    chk("R8", "full clear", status, 16'h0000);

    cur_req = "R4";
    @(negedge clk); pin_in = 8'h01;
    idle(2);
    chk("R4", "not yet after two edges", status, 16'h0000);
    idle(1);
    chk("R4", "pin0 rise after three edges", status, 16'h0100);

    cur_req = "R5";
    wr(0, 16'hFFFF);
    wr(2, 16'h2000);
    @(negedge clk); pin_in = 8'h03;
    idle(4);
    chk("R5", "pin1 rise ignored", status, 16'h0000);
    @(negedge clk); pin_in = 8'h01;
    idle(4);
    chk("R5", "pin1 fall latched", status, 16'h0200);

    cur_req = "R6";
    wr(0, 16'hFFFF);
    @(negedge clk); pin_in = 8'hF1;
    idle(4);
    chk("R6", "upper rise", status, 16'hF000);
    wr(0, 16'hFFFF);
    wr(2, 16'h2100);
    @(negedge clk); pin_in = 8'h51;
    idle(4);
    chk("R6", "upper fall pins 5 7", status, 16'hA000);
    wr(0, 16'hFFFF);
    @(negedge clk); pin_in = 8'hF1;
    idle(4);
    chk("R6", "upper rise ignored", status, 16'h0000);

    cur_req = "R7";
    wr(2, 16'hFFFF);
    chk("R7", "ctrl mask", dio_ctrl, 16'hFD00);
    chk("R7", "both groups out", {14'd0, grp_dir}, 16'h0003);
    wr(2, 16'h0400);
    chk("R7", "group0 out", {14'd0, grp_dir}, 16'h0001);

    cur_req = "R9";
    wr(0, 16'hFFFF);
    @(negedge clk); tmr_evt = 1; wr_en = 1; wr_sel = 0; wr_data = 16'h0001;
    @(negedge clk); tmr_evt = 0; wr_en = 0;
    chk("R9", "event beats clear", status, 16'h0001);

    cur_req = "R10";
    wr(1, 16'hFFFF);
    chk("R10", "bit7 stuck low", irq_en, 16'hFF7F);

    cur_req = "R11";
    chk("R11", "irq on enabled bit", {15'd0, irq}, 16'h0001);
    wr(1, 16'h0002);
    chk("R11", "irq masked", {15'd0, irq}, 16'h0000);
    pulse(0, 0, 0, 4'b0000, 1);
    wr(1, 16'hFFFF);
    wr(0, 16'h0001);
    chk("R11", "mem bit only", status, 16'h0080);
    chk("R11", "mem bit no irq", {15'd0, irq}, 16'h0000);

    cur_req = "R8/R9 random";
    for (int k = 0; k < 1500; k++) begin
      @(negedge clk);
      tmr_evt = ($urandom % 4) == 0;
      dac_evt = ($urandom % 5) == 0;
      adc_evt = ($urandom % 5) == 0;
      mem_evt = ($urandom % 7) == 0;
      cnt_evt = 4'($urandom);
      pin_in  = (($urandom % 3) == 0) ? 8'($urandom) : pin_in;
      wr_en   = ($urandom % 2) == 0;
      wr_sel  = 2'($urandom % 3);
      wr_data = 16'($urandom);
    end
    @(negedge clk); wr_en = 0; tmr_evt = 0; dac_evt = 0; adc_evt = 0; mem_evt = 0; cnt_evt = 0;
    idle(4);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule